// File: doc/BRIEF.md
# Per-Channel Conversion Result Bank

This block keeps the latest conversion result for each of up to 32 channel slots of an analog-to-digital converter. When the converter core finishes a conversion it pulses a completion strobe together with a channel index and a 12-bit result. The bank stores the result in that channel's data word and marks the word as fresh. If a fresh word is overwritten before anyone has read it, the bank records that a result was lost.

Software and DMA engines read the bank through a plain registered read port. Addresses 0 to 31 select a channel's data word. Address 32 returns a summary of all lost-result flags, one bit per channel. Address 33 returns a summary of all fresh flags in the same layout. Reading a channel's data word consumes it and clears both of its flags. Reading a summary word changes nothing. Only slots 0 to 15 and slot 29 are built. Every other slot is permanently empty.

Top module: `rb_result_bank`

## Requirements
- R1: After reset every slot holds result 0 with both flags clear. `rd_ack` is 0, `rd_data` is 0, and both summary words read 0.
- R2: A completion for a present slot stores `cv_result` in bits 11:0 of that slot's data word and sets its fresh flag at bit 17. Bits 15:12 and 31:18 of a data word always read 0.
- R3: A read of a present slot's data word, with no completion for that slot in the same cycle, returns the word as it was and then clears both bit 17 and bit 16. The stored result is kept.
- R4: A completion for a slot whose fresh flag is already 1 sets that slot's lost-result flag at bit 16 and replaces the stored result. The flag stays set until the data word is read.
- R5: When a completion and a data-word read hit the same slot in one cycle, the read returns the previous contents. The slot then holds the new result with the fresh flag 1 and the lost-result flag 0.
- R6: Address 32 returns the lost-result flags, with bit n belonging to slot n. Address 33 returns the fresh flags in the same layout. Reading either address leaves every flag unchanged.
- R7: Slots 16 to 28, 30 and 31 ignore completions. Their data words read 0 and their summary bits read 0.
- R8: Addresses 34 to 63 read 0 and have no side effects.
- R9: `rd_ack` is high exactly one cycle after each cycle with `rd_en` high. `rd_data` carries the word selected in the `rd_en` cycle and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cv_strobe | input | 1 | Conversion completion pulse |
| cv_chan | input | 5 | Slot index of the completed conversion |
| cv_result | input | 12 | Conversion result |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read address: 0-31 data words, 32 lost-result summary, 33 fresh summary |
| rd_ack | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Registered read data |

## Verification
The bench drives completions to the same slot twice in a row, with no read between them. A design that fails to raise the lost-result flag, or that keeps the old result instead of the new one, is caught this way. The bench also issues a completion and a read of the same slot in the same cycle. A design that lets the read clear the fresh flag loses the new result. A design that flags a lost result in that case reports an overrun that never happened. Completions to the empty slots and reads of the summary words and of unused addresses are mixed into a long random sequence. That sequence exposes flags that leak into absent slots and summary reads that clear state.

// File: rtl/rb_pkg.sv
package rb_pkg;
   localparam int WORD_W  = 32;
   localparam int OVR_BIT = 16;
   localparam int VLD_BIT = 17;

   // Data word layout: result in the low field, flags at fixed positions.
   function automatic logic [WORD_W-1:0] pack_word(input logic [OVR_BIT-1:0] res,
                                                   input logic vld, input logic ovr);
      logic [WORD_W-1:0] w;
      w = '0;
      w[OVR_BIT-1:0] = res;
      w[OVR_BIT]     = ovr;
      w[VLD_BIT]     = vld;
      return w;
   endfunction
endpackage

// File: rtl/rb_slot.sv
module rb_slot #(
   parameter int RES_W   = 12,
   parameter bit PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [RES_W-1:0] wr_data,
   input  logic             rd_hit,
   output logic [RES_W-1:0] res,
   output logic             vld,
   output logic             ovr
);
   generate
      if (PRESENT) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res <= '0;
               vld <= 1'b0;
               ovr <= 1'b0;
            end else if (wr_hit) begin
               res <= wr_data;
               vld <= 1'b1;
               ovr <= vld & ~rd_hit;   // a same-cycle read consumed the old value
            end else if (rd_hit) begin
               vld <= 1'b0;
               ovr <= 1'b0;
            end
         end

         a_r4_ovr_implies_vld: assert property (@(posedge clk) disable iff (!rst_n)
            ovr |-> vld);
         a_r4_overwrite_flags: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && vld && !rd_hit) |=> (ovr && vld && res == $past(wr_data)));
         a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit && !wr_hit) |=> (!vld && !ovr && $stable(res)));
         a_r5_collision: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && rd_hit) |=> (vld && !ovr));
      end else begin : g_empty
         logic unused_slot_in;
         assign unused_slot_in = ^{clk, rst_n, wr_hit, wr_data, rd_hit};
         assign res = '0;
         assign vld = 1'b0;
         assign ovr = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rb_readmux.sv
module rb_readmux #(
   parameter int NUM_SLOTS = 32,
   parameter int RES_W     = 12,
   parameter int ADDR_W    = 6
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rd_en,
   input  logic [ADDR_W-1:0]                  rd_addr,
   input  logic [NUM_SLOTS-1:0][RES_W-1:0]    res_arr,
   input  logic [NUM_SLOTS-1:0]               vld_vec,
   input  logic [NUM_SLOTS-1:0]               ovr_vec,
   output logic                               rd_ack,
   output logic [rb_pkg::WORD_W-1:0]          rd_data
);
   import rb_pkg::*;
   localparam int CH_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam logic [ADDR_W-1:0] OVR_ADDR = ADDR_W'(NUM_SLOTS);
   localparam logic [ADDR_W-1:0] VLD_ADDR = ADDR_W'(NUM_SLOTS + 1);

   logic [WORD_W-1:0] word;
   logic [CH_W-1:0]   idx;

   always_comb begin
      idx  = rd_addr[CH_W-1:0];
      word = '0;
      if (rd_addr < OVR_ADDR)
         word = pack_word(OVR_BIT'(res_arr[idx]), vld_vec[idx], ovr_vec[idx]);
      else if (rd_addr == OVR_ADDR)
         word = WORD_W'(ovr_vec);
      else if (rd_addr == VLD_ADDR)
         word = WORD_W'(vld_vec);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= rd_en;
         if (rd_en) rd_data <= word;
      end
   end

   a_r9_ack_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_ack);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!rd_ack && $stable(rd_data)));
   a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr > VLD_ADDR) |=> rd_data == '0);
endmodule

// File: rtl/rb_result_bank.sv
module rb_result_bank #(
   parameter int          NUM_SLOTS = 32,
   parameter int          RES_W     = 12,
   parameter int          ADDR_W    = 6,
   parameter logic [31:0] SLOT_MASK = 32'h2000_FFFF,
   localparam int         CH_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cv_strobe,
   input  logic [CH_W-1:0]   cv_chan,
   input  logic [RES_W-1:0]  cv_result,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ack,
   output logic [31:0]       rd_data
);
   initial begin
      if (NUM_SLOTS < 1 || NUM_SLOTS > 32) $error("NUM_SLOTS must be 1..32");
      if (RES_W < 1 || RES_W > rb_pkg::OVR_BIT) $error("RES_W must fit below the flag bits");
      if ((1 << ADDR_W) < NUM_SLOTS + 2) $error("ADDR_W too small for data and summary words");
   end

   logic [NUM_SLOTS-1:0][RES_W-1:0] res_arr;
   logic [NUM_SLOTS-1:0]            vld_vec;
   logic [NUM_SLOTS-1:0]            ovr_vec;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic wr_hit, rd_hit;
      assign wr_hit = cv_strobe && (cv_chan == CH_W'(i));
      assign rd_hit = rd_en && (rd_addr == ADDR_W'(i));
      rb_slot #(.RES_W(RES_W), .PRESENT(SLOT_MASK[i])) u_slot (
         .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_data(cv_result),
         .rd_hit(rd_hit), .res(res_arr[i]), .vld(vld_vec[i]), .ovr(ovr_vec[i]));
   end

   rb_readmux #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_rmux (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .res_arr(res_arr), .vld_vec(vld_vec), .ovr_vec(ovr_vec),
      .rd_ack(rd_ack), .rd_data(rd_data));

   a_r6_summary_read_pure: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr >= ADDR_W'(NUM_SLOTS) && !cv_strobe) |=>
         (vld_vec == $past(vld_vec) && ovr_vec == $past(ovr_vec)));
   a_r7_empty_slots_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((vld_vec & ~SLOT_MASK[NUM_SLOTS-1:0]) == '0));
endmodule

// File: tb/rb_result_bank_bench.sv
module rb_result_bank_bench;
   localparam logic [31:0] MASK = 32'h2000_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cv_strobe = 1'b0;
   logic [4:0]  cv_chan = '0;
   logic [11:0] cv_result = '0;
   logic        rd_en = 1'b0;
   logic [5:0]  rd_addr = '0;
   logic        rd_ack;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [11:0] m_res [32];
   logic [31:0] m_vld = '0;
   logic [31:0] m_ovr = '0;

   always #2 clk = ~clk;

   rb_result_bank u_rb_result_bank (
      .clk(clk), .rst_n(rst_n), .cv_strobe(cv_strobe), .cv_chan(cv_chan),
      .cv_result(cv_result), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data));

   function automatic logic [31:0] exp_word(input int a);
      logic [31:0] w = '0;
      if (a < 32) begin
         if (MASK[a]) begin
            w[11:0] = m_res[a];
            w[16]   = m_ovr[a];
            w[17]   = m_vld[a];
         end
      end else if (a == 32) w = m_ovr;
      else if (a == 33) w = m_vld;
      return w;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic op(input bit cv, input int ch, input logic [11:0] r,
                     input bit rd, input int a, input string tag_in);
      logic [31:0] exp;
      string tag;
      @(negedge clk);
      cv_strobe = cv; cv_chan = 5'(ch); cv_result = r;
      rd_en = rd; rd_addr = 6'(a);
      exp = exp_word(a);
      tag = tag_in;
      if (tag == "") begin
         if (a >= 34) tag = "R8";
         else if (a >= 32) tag = "R6";
         else if (!MASK[a]) tag = "R7";
         else if (cv && ch == a) tag = "R5";
         else tag = "R3";
      end
      if (cv && MASK[ch]) begin
         if (rd && a == ch) begin
            m_vld[ch] = 1'b1; m_ovr[ch] = 1'b0;
         end else begin
            if (m_vld[ch]) m_ovr[ch] = 1'b1;
            m_vld[ch] = 1'b1;
         end
         m_res[ch] = r;
      end
      if (rd && a < 32 && !(cv && ch == a)) begin
         m_vld[a] = 1'b0; m_ovr[a] = 1'b0;
      end
      @(posedge clk); #1;
      check("R9 ack", 32'(rd_ack), 32'(rd));
      if (rd) check(tag, rd_data, exp);
      cv_strobe = 1'b0; rd_en = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0BADC0DE));
      for (int i = 0; i < 32; i++) m_res[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 ack", 32'(rd_ack), 32'd0);
      check("R1 data", rd_data, 32'd0);
      rst_n = 1'b1;
      op(0, 0, 0, 1, 32, "R1 ovr summary");
      op(0, 0, 0, 1, 33, "R1 vld summary");
      op(0, 0, 0, 1, 3, "R1 slot3");
      // R2: store and tag fresh
      op(1, 3, 12'hABC, 0, 0, "");
      op(0, 0, 0, 1, 3, "R2 fresh word");
      check("R2 literal", rd_data, 32'h0002_0ABC);
      op(0, 0, 0, 1, 3, "R3 flags cleared");
      check("R3 literal", rd_data, 32'h0000_0ABC);
      // R4: overwrite before read
      op(1, 5, 12'h111, 0, 0, "");
      op(1, 5, 12'h222, 0, 0, "");
      op(0, 0, 0, 1, 32, "R6 ovr bit5");
      op(0, 0, 0, 1, 33, "R6 vld bit5 after summary read");
      op(0, 0, 0, 1, 5, "R4 overrun word");
      check("R4 literal", rd_data, 32'h0003_0222);
      op(0, 0, 0, 1, 32, "R3 overrun cleared");
      // R7: slot 29 present, slot 20 and 31 absent
      op(1, 29, 12'hFFF, 0, 0, "");
      op(1, 20, 12'h123, 0, 0, "");
      op(1, 31, 12'h321, 0, 0, "");
      op(0, 0, 0, 1, 20, "R7 absent slot");
      op(0, 0, 0, 1, 31, "R7 absent slot 31");
      op(0, 0, 0, 1, 33, "R7 summary");
      check("R7 literal", rd_data, 32'h2000_0000);
      // R5: collision
      op(1, 7, 12'h055, 0, 0, "");
      op(1, 7, 12'h066, 1, 7, "R5 read returns old");
      check("R5 literal old", rd_data, 32'h0002_0055);
      op(0, 0, 0, 1, 7, "R5 new stored no overrun");
      check("R5 literal new", rd_data, 32'h0002_0066);
      // R8: unused addresses
      op(0, 0, 0, 1, 40, "R8 addr40");
      op(0, 0, 0, 1, 63, "R8 addr63");
      // random mix
      for (int n = 0; n < 1500; n++) begin
         int ch, a, sel;
         bit cv, rd;
         cv  = ($urandom % 2) == 0;
         ch  = $urandom % 32;
         rd  = ($urandom % 3) != 0;
         sel = $urandom % 10;
         if (sel < 6) a = $urandom % 32;
         else if (sel < 8) a = 32 + ($urandom % 2);
         else if (sel < 9) a = ch;
         else a = $urandom % 64;
         op(cv, ch, 12'($urandom), rd, a, "");
      end
      for (int i = 0; i < 34; i++) op(0, 0, 0, 1, i, "");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule